// File: doc/BRIEF.md
# Trap and Exception-Return Program Counter Control

This block chooses the program counter that follows the instruction now in flight. It deals with two special control transfers. A software trap jumps to an absolute address made from the 26-bit name field of a J-type instruction, and it saves a return address in a dedicated link register. A return-from-exception jumps back to the address held in that link register. Any other instruction, including a decoded no-op, gets the plain sequential successor, PC+4.

The link register is called the exception return register. A trap writes PC+8 into it. The extra word steps over the branch delay slot that follows the trap. The register is written by nothing else, so a no-op or a return leaves it unchanged.

All outputs are registered. The strobes and operands sampled at a rising clock edge appear on the outputs just after that edge. The pipeline uses the redirect strobe to squash its fall-through fetch. Instruction fetch, general decode, privilege handling and ordinary branches live elsewhere.

Top module: `trap_pc_ctrl`

## Requirements
- R1: While reset is asserted, and on the first edge after it, next_pc_o, redirect_o and ret_addr_o are all zero.
- R2: A trap sampled at an edge sets next_pc_o, after that edge, to the 26-bit name field placed in bits 25:0 with bits 31:26 zero.
- R3: A trap sampled at an edge loads ret_addr_o with the sampled PC plus 8, modulo 2^32.
- R4: A return-from-exception without a trap sets next_pc_o to the ret_addr_o value held before that edge.
- R5: redirect_o is 1 after an edge where a trap or a return was sampled, and 0 after every other edge.
- R6: When neither a trap nor a return is sampled, next_pc_o becomes the sampled PC plus 4, modulo 2^32.
- R7: A no-op alone leaves ret_addr_o unchanged, keeps redirect_o at 0 and gives PC+4.
- R8: When a trap and a return are sampled together, the trap wins and the return is ignored.
- R9: ret_addr_o changes only on a trap. A return does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_i | input | 32 | Address of the instruction being resolved |
| name_i | input | 26 | Name field of the J-type instruction |
| trap_i | input | 1 | Decoded trap strobe |
| rfe_i | input | 1 | Decoded return-from-exception strobe |
| nop_i | input | 1 | Decoded no-op strobe |
| next_pc_o | output | 32 | Registered next program counter |
| redirect_o | output | 1 | Registered one-cycle non-sequential transfer flag |
| ret_addr_o | output | 32 | Exception return register contents |

## Verification
The bound checker watches the decoder's fire wires on every cycle. It checks that exactly one path is selected and that trap priority holds. One cycle later it checks the trap target, the PC+8 link value, the return target, the sequential step, the redirect flag, and that the return register stays stable except on a trap.

Some behaviour only the bench scenarios can show. These are the reset values, the 32-bit wraparound of PC+4 and PC+8 at the top of the address space, and a name field of all ones that must still leave the top six bits clear. They also include trap-then-return sequences, where the return must use the value the earlier trap stored.

// File: rtl/trap_pc_pkg.sv
package trap_pc_pkg;

  // Path chosen for the next program counter.
  typedef enum logic [1:0] {
    PATH_SEQ    = 2'd0,
    PATH_TRAP   = 2'd1,
    PATH_RETURN = 2'd2
  } pc_path_e;

endpackage

// File: rtl/trap_pc_sel.sv
// Priority decode of the special-instruction strobes: trap beats return,
// and anything else (including a no-op) takes the sequential path.
module trap_pc_sel
  import trap_pc_pkg::*;
(
  input  logic     trap_i,
  input  logic     rfe_i,
  input  logic     nop_i,
  output pc_path_e path_o,
  output logic     trap_fire_o,
  output logic     ret_fire_o,
  output logic     seq_fire_o,
  output logic     nop_fire_o
);

  always_comb begin
    trap_fire_o = trap_i;
    ret_fire_o  = rfe_i & ~trap_i;
    seq_fire_o  = ~trap_i & ~rfe_i;
    nop_fire_o  = nop_i & ~trap_i & ~rfe_i;
    if (trap_i)     path_o = PATH_TRAP;
    else if (rfe_i) path_o = PATH_RETURN;
    else            path_o = PATH_SEQ;
  end

endmodule

// File: rtl/trap_pc_link.sv
// Exception return register: written with PC + delay-slot span on a trap only.
module trap_pc_link #(
  parameter int XLEN       = 32,
  parameter int SLOT_BYTES = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_fire_i,
  input  logic [XLEN-1:0] pc_i,
  output logic [XLEN-1:0] ret_addr_o
);

  localparam logic [XLEN-1:0] SLOT_SPAN = XLEN'(SLOT_BYTES);

  function automatic logic [XLEN-1:0] link_addr(input logic [XLEN-1:0] pc);
    return pc + SLOT_SPAN;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)           ret_addr_o <= '0;
    else if (trap_fire_i) ret_addr_o <= link_addr(pc_i);
  end

endmodule

// File: rtl/trap_pc_next.sv
// Registered next-PC mux and redirect flag.
module trap_pc_next
  import trap_pc_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int NAME_W     = 26,
  parameter int STEP_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pc_path_e          path_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [NAME_W-1:0] name_i,
  input  logic [XLEN-1:0]   ret_addr_i,
  output logic [XLEN-1:0]   next_pc_o,
  output logic              redirect_o
);

  localparam int              PAD_W     = XLEN - NAME_W;
  localparam logic [XLEN-1:0] STEP_SPAN = XLEN'(STEP_BYTES);

  function automatic logic [XLEN-1:0] seq_addr(input logic [XLEN-1:0] pc);
    return pc + STEP_SPAN;
  endfunction

  function automatic logic [XLEN-1:0] trap_addr(input logic [NAME_W-1:0] nm);
    return {{PAD_W{1'b0}}, nm};
  endfunction

  logic [XLEN-1:0] pc_d;
  logic            redir_d;

  always_comb begin
    unique case (path_i)
      PATH_TRAP:   begin pc_d = trap_addr(name_i); redir_d = 1'b1; end
      PATH_RETURN: begin pc_d = ret_addr_i;        redir_d = 1'b1; end
      default:     begin pc_d = seq_addr(pc_i);    redir_d = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_pc_o  <= '0;
      redirect_o <= 1'b0;
    end else begin
      next_pc_o  <= pc_d;
      redirect_o <= redir_d;
    end
  end

endmodule

// File: rtl/trap_pc_ctrl.sv
module trap_pc_ctrl
  import trap_pc_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int NAME_W     = 26,
  parameter int STEP_BYTES = 4,
  parameter int SLOT_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [NAME_W-1:0] name_i,
  input  logic              trap_i,
  input  logic              rfe_i,
  input  logic              nop_i,
  output logic [XLEN-1:0]   next_pc_o,
  output logic              redirect_o,
  output logic [XLEN-1:0]   ret_addr_o
);

  pc_path_e path;
  logic     trap_fire, ret_fire, seq_fire, nop_fire;

  trap_pc_sel u_sel (
    .trap_i      (trap_i),
    .rfe_i       (rfe_i),
    .nop_i       (nop_i),
    .path_o      (path),
    .trap_fire_o (trap_fire),
    .ret_fire_o  (ret_fire),
    .seq_fire_o  (seq_fire),
    .nop_fire_o  (nop_fire)
  );

  trap_pc_link #(.XLEN(XLEN), .SLOT_BYTES(SLOT_BYTES)) u_link (
    .clk         (clk),
    .rst_n       (rst_n),
    .trap_fire_i (trap_fire),
    .pc_i        (pc_i),
    .ret_addr_o  (ret_addr_o)
  );

  trap_pc_next #(.XLEN(XLEN), .NAME_W(NAME_W), .STEP_BYTES(STEP_BYTES)) u_next (
    .clk        (clk),
    .rst_n      (rst_n),
    .path_i     (path),
    .pc_i       (pc_i),
    .name_i     (name_i),
    .ret_addr_i (ret_addr_o),
    .next_pc_o  (next_pc_o),
    .redirect_o (redirect_o)
  );

endmodule

// File: rtl/trap_pc_ctrl_chk.sv
module trap_pc_ctrl_chk #(
  parameter int XLEN       = 32,
  parameter int NAME_W     = 26,
  parameter int STEP_BYTES = 4,
  parameter int SLOT_BYTES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [XLEN-1:0]   pc_i,
  input logic [NAME_W-1:0] name_i,
  input logic              trap_i,
  input logic              rfe_i,
  input logic [XLEN-1:0]   next_pc_o,
  input logic              redirect_o,
  input logic [XLEN-1:0]   ret_addr_o,
  input logic              trap_fire,
  input logic              ret_fire,
  input logic              seq_fire,
  input logic              nop_fire
);

  // R8
  one_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({trap_fire, ret_fire, seq_fire}) == 1 && !(trap_i && ret_fire));

  // R2
  trap_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_fire |=> next_pc_o == XLEN'($past(name_i)));

  // R3
  link_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_fire |=> ret_addr_o == $past(pc_i) + XLEN'(SLOT_BYTES));

  // R4
  return_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_fire |=> next_pc_o == $past(ret_addr_o));

  // R5
  redirect_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_i || rfe_i) |=> redirect_o);

  // R6
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_fire |=> next_pc_o == $past(pc_i) + XLEN'(STEP_BYTES) && !redirect_o);

  // R7
  nop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nop_fire |=> $stable(ret_addr_o) && !redirect_o);

  // R9
  link_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_i |=> $stable(ret_addr_o));

endmodule

bind trap_pc_ctrl trap_pc_ctrl_chk #(
  .XLEN(XLEN), .NAME_W(NAME_W), .STEP_BYTES(STEP_BYTES), .SLOT_BYTES(SLOT_BYTES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pc_i       (pc_i),
  .name_i     (name_i),
  .trap_i     (trap_i),
  .rfe_i      (rfe_i),
  .next_pc_o  (next_pc_o),
  .redirect_o (redirect_o),
  .ret_addr_o (ret_addr_o),
  .trap_fire  (trap_fire),
  .ret_fire   (ret_fire),
  .seq_fire   (seq_fire),
  .nop_fire   (nop_fire)
);

// File: tb/test_trap_pc_ctrl.sv
`timescale 1ns/1ps
module test_trap_pc_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] pc_i;
  logic [25:0] name_i;
  logic        trap_i, rfe_i, nop_i;
  logic [31:0] next_pc_o, ret_addr_o;
  logic        redirect_o;

  int checks = 0;
  int fails  = 0;
  logic [31:0] m_ret;   // bench model of the return register

  always #10 clk = ~clk;   // 50 MHz

  trap_pc_ctrl i_trap_pc_ctrl (
    .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .name_i(name_i),
    .trap_i(trap_i), .rfe_i(rfe_i), .nop_i(nop_i),
    .next_pc_o(next_pc_o), .redirect_o(redirect_o), .ret_addr_o(ret_addr_o)
  );

  function automatic logic [31:0] exp_target(input logic [25:0] nm);
    return 32'(nm) & 32'h03FF_FFFF;
  endfunction
  function automatic logic [31:0] plus(input logic [31:0] a, input int unsigned k);
    return 32'((64'(a) + 64'(k)) % 64'h1_0000_0000);
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic t, input logic r, input logic n,
                      input logic [31:0] pc, input logic [25:0] nm, input string tag);
    logic [31:0] e_pc, e_ret;
    logic        e_red;
    @(negedge clk);
    trap_i = t; rfe_i = r; nop_i = n; pc_i = pc; name_i = nm;
    if (t)      begin e_pc = exp_target(nm); e_red = 1'b1; e_ret = plus(pc, 8); end
    else if (r) begin e_pc = m_ret;          e_red = 1'b1; e_ret = m_ret;       end
    else        begin e_pc = plus(pc, 4);    e_red = 1'b0; e_ret = m_ret;       end
    @(posedge clk); #2;
    chk(tag, "next_pc", next_pc_o, e_pc);
    chk(tag, "redirect", 32'(redirect_o), 32'(e_red));
    chk(tag, "ret_addr", ret_addr_o, e_ret);
    m_ret = e_ret;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; trap_i = 1'b1; rfe_i = 1'b0; nop_i = 1'b0;
    pc_i = 32'h1234_5678; name_i = 26'h3AB_CDEF; m_ret = '0;
    repeat (3) @(posedge clk);
    #2;
    // R1: outputs held at zero during reset even with a trap asserted
    chk("R1", "next_pc", next_pc_o, 32'h0);
    chk("R1", "redirect", 32'(redirect_o), 32'h0);
    chk("R1", "ret_addr", ret_addr_o, 32'h0);
    @(negedge clk); trap_i = 1'b0; rst_n = 1'b1;

    step(1'b0, 1'b0, 1'b0, 32'h0000_0000, 26'h0, "R6");
    // R2: all-ones name field, top bits must stay zero
    step(1'b1, 1'b0, 1'b0, 32'h0000_0100, 26'h3FF_FFFF, "R2");
    // R4: return uses value stored by the trap
    step(1'b0, 1'b1, 1'b0, 32'h0000_0200, 26'h0, "R4");
    // R5: redirect drops afterwards
    step(1'b0, 1'b0, 1'b0, 32'h0000_0300, 26'h0, "R5");
    // R3: link wraps at top of address space
    step(1'b1, 1'b0, 1'b0, 32'hFFFF_FFFC, 26'h000_0040, "R3");
    // R9: return leaves register alone; repeated returns
    step(1'b0, 1'b1, 1'b0, 32'h0000_0500, 26'h155_5555, "R9");
    step(1'b0, 1'b1, 1'b0, 32'h0000_0600, 26'h0AA_AAAA, "R9");
    // R6: sequential wrap
    step(1'b0, 1'b0, 1'b0, 32'hFFFF_FFFC, 26'h0, "R6");
    // R7: no-op with a name field present
    step(1'b0, 1'b0, 1'b1, 32'h8000_0000, 26'h2AA_AAAA, "R7");
    // R8: trap and return together
    step(1'b1, 1'b1, 1'b0, 32'h0000_1000, 26'h012_3456, "R8");
    step(1'b1, 1'b1, 1'b1, 32'h0000_2000, 26'h3FF_0000, "R8");

    for (int i = 0; i < 3000; i++) begin
      int unsigned kind = $urandom % 8;
      logic t = (kind == 0) || (kind == 7);
      logic r = (kind == 1) || (kind == 7);
      logic n = (kind == 2);
      string tag = t ? (r ? "R8" : "R2") : (r ? "R4" : (n ? "R7" : "R6"));
      step(t, r, n, $urandom & 32'hFFFF_FFFC, 26'($urandom), tag);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule